// File: doc/BRIEF.md
# Three-Bank Rotating Frame FIFO with Serial Snapshot

This block buffers hit words between a pixel matrix and a downstream merge stage using three identical small FIFO banks. On every bunch-crossing boundary the banks swap duties in a fixed cycle. One bank collects the words of the current frame. A second bank hands the previous frame's words to the merge stage. The third bank is wiped so that it is empty when its next collecting turn begins. Collecting, draining and wiping therefore happen side by side in every frame.

A capture request copies the fill level and stored words of all three banks into a separate shift register. Normal traffic does not pause. The copy is then clocked out one bit at a time. A serial input lets several instances be linked into one long chain across column groups.

Top module: `tri_phase_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, all banks become empty, the snapshot register is cleared to zero, and `frame_ovf` is low. The roles come out of reset as follows: bank 0 collects, bank 2 drains and bank 1 is wiped.
- R2: At each clock edge where `bx_tick` is high, every bank moves to its next role in the order collect, then drain, then wipe, then collect again. The next collecting bank has index (current + 1) mod 3. The three roles are always held by three different banks.
- R3: While `wr_valid` is high and the collecting bank holds fewer than DEPTH words, `wr_data` is stored. After the next rotation, the stored words come out in their arrival order.
- R4: A write that arrives while the collecting bank is full is discarded. It sets `frame_ovf` from the next cycle on. `frame_ovf` stays set until the next `bx_tick` edge, which clears it.
- R5: `rd_valid` is high exactly while the draining bank holds words, and `rd_data` is its oldest word. A word is removed at an edge where `rd_valid` and `rd_ready` are both high.
- R6: The wiping bank is emptied. Words not drained before a bank leaves the drain role are lost, and a bank always begins its collecting turn empty.
- R7: A clock edge with `snap_capture` high loads the snapshot register with the state that all three banks held before that edge. Capturing has no effect on stored words, reads or writes. Capture takes priority over shifting.
- R8: The snapshot holds one segment per bank, with bank 0 at the most significant end. Each segment is the bank's fill level (clog2(DEPTH+1) bits) followed by DEPTH word slots, oldest stored word first. Slots beyond the fill level read as zero, and every field is most significant bit first.
- R9: At an edge where `snap_shift` is high and `snap_capture` is low, the snapshot moves one place toward its most significant end, and `snap_in` enters at the least significant bit. `snap_out` always shows the most significant bit. With neither request, `snap_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bx_tick | input | 1 | One-cycle pulse marking the end of a bunch-crossing period |
| wr_valid | input | 1 | Matrix word present |
| wr_data | input | W | Matrix word |
| rd_ready | input | 1 | Merge stage accepts the offered word |
| rd_valid | output | 1 | Draining bank has a word on offer |
| rd_data | output | W | Oldest word of the draining bank |
| frame_ovf | output | 1 | A write was dropped in the current frame |
| snap_capture | input | 1 | Copy all bank state into the snapshot register |
| snap_shift | input | 1 | Advance the snapshot chain by one bit |
| snap_in | input | 1 | Serial input from the upstream neighbour |
| snap_out | output | 1 | Serial output to the downstream neighbour |

## Verification
The bench uses the default build: 8-bit words and five-deep banks. With these values a single frame of six or seven writes reaches the full and dropped-write corners. Within nine frames every bank completes its rotation three times, so a bank that was left half drained is later seen starting empty. At this size the snapshot chain is 129 bits long, so a complete shift-out, plus eight extra bits that show `snap_in` coming through, fits in one short directed test.

// File: rtl/rfifo_pkg.sv
// Shared definitions for the rotating frame FIFO.
// Assumes exactly three banks; the role cycle is fixed by that count.
package rfifo_pkg;

    localparam int unsigned NUM_BANKS = 3;

    typedef enum logic [1:0] {
        ROLE_COLLECT = 2'd0,
        ROLE_DRAIN   = 2'd1,
        ROLE_WIPE    = 2'd2
    } role_e;

    // Successor of a bank slot index in the three-way rotation.
    function automatic logic [1:0] next_slot(input logic [1:0] s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction

endpackage

// File: rtl/rfifo_role_seq.sv
// Role sequencer: a three-state phase that advances on every bunch-crossing
// tick, with the role of each bank decoded from it.
// Assumes bx_tick is a single-cycle pulse in the clk domain.
module rfifo_role_seq
    import rfifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bx_tick,
    output logic [NUM_BANKS-1:0] is_collect,
    output logic [NUM_BANKS-1:0] is_drain,
    output logic [NUM_BANKS-1:0] is_wipe
);

    logic [1:0] phase_q;

    // Advance the phase at every tick; phase value names the collecting bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 2'd0;
        else if (bx_tick)
            phase_q <= next_slot(phase_q);
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_role
        role_e role;

        // Bank i drains one phase after it collected, is wiped one after that.
        always_comb begin
            if (phase_q == 2'(i))
                role = ROLE_COLLECT;
            else if (phase_q == next_slot(2'(i)))
                role = ROLE_DRAIN;
            else
                role = ROLE_WIPE;
        end

        assign is_collect[i] = (role == ROLE_COLLECT);
        assign is_drain[i]   = (role == ROLE_DRAIN);
        assign is_wipe[i]    = (role == ROLE_WIPE);
    end

endmodule

// File: rtl/rfifo_bank.sv
// One circular FIFO bank with a synchronous wipe and a flat view of its
// contents, oldest word first, unused slots forced to zero.
// Assumes push and pop may be requested in the same cycle; a push when full
// and a pop when empty are ignored here.
module rfifo_bank #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [W-1:0]                   wdata,
    input  logic                           pop,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     level,
    output logic [DEPTH*W-1:0]             view
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] level_q;
    logic          push_ok, pop_ok;

    assign push_ok = push && (level_q != CW'(DEPTH));
    assign pop_ok  = pop  && (level_q != '0);

    // Pointer and fill-level bookkeeping, cleared by reset or wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok)
                wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
            if (pop_ok)
                rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
            level_q <= level_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Word storage; contents beyond the fill level are never observed.
    always_ff @(posedge clk) begin
        if (push_ok && !clr)
            mem[wptr_q] <= wdata;
    end

    // Oldest-first view of stored words, zero past the fill level.
    always_comb begin
        logic [PW:0] slot;
        view = '0;
        for (int j = 0; j < DEPTH; j++) begin
            slot = {1'b0, rptr_q} + (PW+1)'(j);
            if (slot >= (PW+1)'(DEPTH))
                slot = slot - (PW+1)'(DEPTH);
            if (CW'(j) < level_q)
                view[(DEPTH-1-j)*W +: W] = mem[slot[PW-1:0]];
        end
    end

    assign head  = mem[rptr_q];
    assign level = level_q;

endmodule

// File: rtl/rfifo_snap_chain.sv
// Snapshot shift register: parallel capture, serial shift toward the MSB.
// Assumes capture wins over shift when both are requested.
module rfifo_snap_chain #(
    parameter int unsigned LEN = 129
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [LEN-1:0] load_bits,
    input  logic           shift,
    input  logic           ser_in,
    output logic           ser_out
);

    logic [LEN-1:0] chain_q;

    // Load on capture, otherwise shift one place when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (capture)
            chain_q <= load_bits;
        else if (shift)
            chain_q <= {chain_q[LEN-2:0], ser_in};
    end

    assign ser_out = chain_q[LEN-1];

endmodule

// File: rtl/tri_phase_fifo.sv
// Top level: three FIFO banks rotating through collect, drain and wipe
// roles per bunch-crossing period, plus a non-intrusive snapshot chain.
// Assumes bx_tick is a single-cycle pulse; the merge stage may stall freely.
module tri_phase_fifo
    import rfifo_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bx_tick,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         frame_ovf,
    input  logic         snap_capture,
    input  logic         snap_shift,
    input  logic         snap_in,
    output logic         snap_out
);

    localparam int unsigned CW        = $clog2(DEPTH + 1);
    localparam int unsigned SEG       = CW + DEPTH * W;
    localparam int unsigned CHAIN_LEN = NUM_BANKS * SEG;

    logic [NUM_BANKS-1:0] is_collect, is_drain, is_wipe;
    logic [CW-1:0]        level_a [NUM_BANKS];
    logic [W-1:0]         head_a  [NUM_BANKS];
    logic [DEPTH*W-1:0]   view_a  [NUM_BANKS];
    logic [CW-1:0]        writer_cnt, reader_cnt;
    logic [W-1:0]         reader_head;
    logic [CHAIN_LEN-1:0] cap_bits;
    logic                 ovf_q;

    rfifo_role_seq seq_u (
        .clk        (clk),
        .rst_n      (rst_n),
        .bx_tick    (bx_tick),
        .is_collect (is_collect),
        .is_drain   (is_drain),
        .is_wipe    (is_wipe)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        rfifo_bank #(.W(W), .DEPTH(DEPTH)) bank_u (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (is_wipe[i]),
            .push  (wr_valid && is_collect[i]),
            .wdata (wr_data),
            .pop   (rd_ready && is_drain[i]),
            .head  (head_a[i]),
            .level (level_a[i]),
            .view  (view_a[i])
        );
        // Bank 0 occupies the most significant segment of the snapshot.
        assign cap_bits[(NUM_BANKS-1-i)*SEG +: SEG] = {level_a[i], view_a[i]};
    end

    // Select the fill levels and head word of the banks in active roles.
    always_comb begin
        writer_cnt  = '0;
        reader_cnt  = '0;
        reader_head = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (is_collect[i])
                writer_cnt = writer_cnt | level_a[i];
            if (is_drain[i]) begin
                reader_cnt  = reader_cnt | level_a[i];
                reader_head = reader_head | head_a[i];
            end
        end
    end

    // Frame overflow flag: set by a write into a full bank, cleared per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (bx_tick)
            ovf_q <= 1'b0;
        else if (wr_valid && (writer_cnt == CW'(DEPTH)))
            ovf_q <= 1'b1;
    end

    rfifo_snap_chain #(.LEN(CHAIN_LEN)) snap_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (snap_capture),
        .load_bits (cap_bits),
        .shift     (snap_shift),
        .ser_in    (snap_in),
        .ser_out   (snap_out)
    );

    assign rd_valid  = (reader_cnt != '0);
    assign rd_data   = reader_head;
    assign frame_ovf = ovf_q;

endmodule

// File: rtl/tri_phase_fifo_chk.sv
// Property checker for tri_phase_fifo, attached by bind.
// Assumes it observes the top's role vectors, active-bank levels and
// snapshot load vector alongside the ports.
module tri_phase_fifo_chk
    import rfifo_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 5,
    parameter int unsigned CW    = $clog2(DEPTH + 1),
    parameter int unsigned LEN   = 129
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bx_tick,
    input logic                 rd_valid,
    input logic                 rd_ready,
    input logic                 frame_ovf,
    input logic                 snap_capture,
    input logic                 snap_shift,
    input logic                 snap_out,
    input logic [NUM_BANKS-1:0] is_collect,
    input logic [NUM_BANKS-1:0] is_drain,
    input logic [NUM_BANKS-1:0] is_wipe,
    input logic [CW-1:0]        writer_cnt,
    input logic [CW-1:0]        reader_cnt,
    input logic [LEN-1:0]       cap_bits
);

    // R2: roles always held by three distinct banks
    a_r2_roles_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({is_collect, is_drain, is_wipe}) == 3) &&
        ($countones(is_collect | is_drain | is_wipe) == 3));

    // R2: collecting duty moves to the next bank index at a tick
    a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick |=> is_collect == {$past(is_collect[1:0]), $past(is_collect[2])});

    // R2: the bank that collected becomes the draining bank
    a_r2_collect_to_drain: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick |=> is_drain == $past(is_collect));

    // R6: a bank starts its collecting turn empty
    a_r6_fresh_writer: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick |=> writer_cnt == '0);

    // R3: collecting bank never exceeds its depth
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        writer_cnt <= CW'(DEPTH));

    // R4: flag cleared by a tick, held otherwise
    a_r4_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick |=> !frame_ovf);
    a_r4_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf && !bx_tick |=> frame_ovf);

    // R5: an accepted word leaves the draining bank
    a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && !bx_tick |=> reader_cnt == $past(reader_cnt) - CW'(1));

    // R7: capture presents the pre-edge bank state at the chain head
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_capture |=> snap_out == $past(cap_bits[LEN-1]));

    // R9: chain holds still without a request
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_capture && !snap_shift |=> $stable(snap_out));

endmodule

bind tri_phase_fifo tri_phase_fifo_chk #(
    .W     (W),
    .DEPTH (DEPTH),
    .CW    (CW),
    .LEN   (CHAIN_LEN)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bx_tick      (bx_tick),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .frame_ovf    (frame_ovf),
    .snap_capture (snap_capture),
    .snap_shift   (snap_shift),
    .snap_out     (snap_out),
    .is_collect   (is_collect),
    .is_drain     (is_drain),
    .is_wipe      (is_wipe),
    .writer_cnt   (writer_cnt),
    .reader_cnt   (reader_cnt),
    .cap_bits     (cap_bits)
);

// File: tb/tri_phase_fifo_tb_top.sv
`timescale 1ns/1ps
module tri_phase_fifo_tb_top;

    localparam int W     = 8;
    localparam int DEPTH = 5;
    localparam int LEN   = 129;
    localparam int NFR   = 9;

    // Frame vectors: {writes, first data value, read attempts}
    localparam logic [23:0] FRAMES [NFR] = '{
        {8'd3, 8'h10, 8'd0},
        {8'd5, 8'h20, 8'd4},
        {8'd7, 8'h30, 8'd2},
        {8'd0, 8'h00, 8'd6},
        {8'd2, 8'h40, 8'd1},
        {8'd1, 8'h50, 8'd3},
        {8'd4, 8'h60, 8'd2},
        {8'd5, 8'h70, 8'd5},
        {8'd6, 8'h80, 8'd6}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bx_tick = 1'b0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_ready = 1'b0;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic         frame_ovf;
    logic         snap_capture = 1'b0;
    logic         snap_shift = 1'b0;
    logic         snap_in = 1'b0;
    logic         snap_out;

    int n_checks = 0;
    int n_fail   = 0;
    int prev_cnt  = 0;
    logic [7:0] prev_base = '0;

    always #2.5 clk = ~clk;

    tri_phase_fifo #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bx_tick      (bx_tick),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .rd_ready     (rd_ready),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .frame_ovf    (frame_ovf),
        .snap_capture (snap_capture),
        .snap_shift   (snap_shift),
        .snap_in      (snap_in),
        .snap_out     (snap_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; bx_tick = 0; wr_valid = 0; rd_ready = 0;
        snap_capture = 0; snap_shift = 0; snap_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_cnt = 0;
        prev_base = '0;
    endtask

    // One frame: writes into the collecting bank, reads from the draining bank,
    // then a tick. Expected reads follow the previous frame's stored words.
    task automatic run_frame(input int nwr, input logic [7:0] base, input int nrd);
        int ncyc;
        ncyc = (nwr > nrd) ? nwr : nrd;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            wr_valid = (c < nwr);
            wr_data  = base + 8'(c);
            rd_ready = (c < nrd);
            #1;
            if (c < nrd) begin
                check(rd_valid == (c < prev_cnt), (c < prev_cnt) ? "R5" : "R6",
                      32'(rd_valid), 32'(c < prev_cnt));
                if (c < prev_cnt)
                    check(rd_data == prev_base + 8'(c), "R3", 32'(rd_data),
                          32'(prev_base + 8'(c)));
            end
        end
        @(negedge clk);
        wr_valid = 0; rd_ready = 0; bx_tick = 1;
        #1;
        check(frame_ovf == (nwr > DEPTH), "R4", 32'(frame_ovf), 32'(nwr > DEPTH));
        @(negedge clk);
        bx_tick = 0;
        #1;
        check(frame_ovf == 1'b0, "R4", 32'(frame_ovf), 32'd0);
        // R2: the bank just filled is now offering its words
        check(rd_valid == (nwr > 0), "R2", 32'(rd_valid), 32'(nwr > 0));
        prev_cnt  = (nwr > DEPTH) ? DEPTH : nwr;
        prev_base = base;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [LEN-1:0] exp_snap;
        logic [LEN-1:0] got_snap;
        logic [7:0]     pat;
        logic [7:0]     got_pat;

        apply_reset();
        #1;
        // R1: reset state at the ports
        check(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);
        check(frame_ovf == 1'b0, "R1", 32'(frame_ovf), 32'd0);
        check(snap_out == 1'b0, "R1", 32'(snap_out), 32'd0);

        // Vector-driven frames: R2, R3, R4, R5, R6
        for (int k = 0; k < NFR; k++)
            run_frame(int'(FRAMES[k][23:16]), FRAMES[k][15:8], int'(FRAMES[k][7:0]));

        // Snapshot test: R1 role order, R7 capture, R8 layout, R9 shift
        apply_reset();
        run_frame(3, 8'hA1, 0);          // bank 0 collects A1..A3
        @(negedge clk);
        wr_valid = 1; wr_data = 8'hD4; rd_ready = 1;
        #1;
        check(rd_data == 8'hA1, "R1", 32'(rd_data), 32'hA1);
        @(negedge clk);
        wr_data = 8'hE5; snap_capture = 1;
        #1;
        check(rd_data == 8'hA2, "R3", 32'(rd_data), 32'hA2);
        @(negedge clk);
        wr_valid = 0; rd_ready = 0; snap_capture = 0;
        #1;
        // R7: capture left the drain order untouched
        check(rd_valid && rd_data == 8'hA3, "R7", 32'(rd_data), 32'hA3);

        exp_snap = {3'd2, 8'hA2, 8'hA3, 24'h0,
                    3'd1, 8'hD4, 32'h0,
                    3'd0, 40'h0};
        pat = 8'b1011_0010;
        for (int i = 0; i < LEN + 8; i++) begin
            @(negedge clk);
            #1;
            if (i < LEN) got_snap[LEN-1-i] = snap_out;
            else         got_pat[7-(i-LEN)] = snap_out;
            snap_shift = 1;
            snap_in = (i < 8) ? pat[7-i] : 1'b0;
        end
        @(negedge clk);
        snap_shift = 0;
        n_checks++;
        if (got_snap !== exp_snap) begin
            n_fail++;
            $display("FAIL R8: actual %h expected %h", got_snap, exp_snap);
        end
        check(got_pat == pat, "R9", 32'(got_pat), 32'(pat));

        // R7: a write made during capture also survives
        @(negedge clk);
        bx_tick = 1;
        @(negedge clk);
        bx_tick = 0;
        #1;
        check(rd_valid && rd_data == 8'hD4, "R7", 32'(rd_data), 32'hD4);
        @(negedge clk);
        rd_ready = 1;
        @(negedge clk);
        rd_ready = 0;
        #1;
        check(rd_valid && rd_data == 8'hE5, "R7", 32'(rd_data), 32'hE5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule